// File: doc/BRIEF.md
# Bidirectional Link Direction Controller

This block sits at one end of a shared bidirectional link between two neighbouring routers and decides, cycle by cycle, whether its end drives the link or receives from it. A controller is placed at each end. One is built as the high-priority end and the other as the low-priority end. For the companion link between the same two routers, the priorities are swapped. Both controllers run on one clock. Each one's `output_req` is wired to the other's `input_req`. The local routing computation raises `channel_req` while a granted packet needs this link.

Each controller holds one of three states:

- **Idle**: the link points inward and this end receives.
- **Wait**: this end has asked for the link and is waiting for the other end to let go.
- **Free**: this end owns the link and drives it.

The owner keeps the link while it has traffic. It gives the link up only when it has nothing to send and the other end is asking. A waiting end takes over on the same clock edge at which the owner lets go. If both ends ask for an unowned link at once, the high-priority end wins. A low-priority end that meets a competing request backs off.

The block has only control pins. There is no streaming data interface, so there is no valid/ready handshake or back-pressure. `output_req` is combinational from the state register, `channel_req` and (low-priority end only) `input_req`. Because the high-priority end's request never depends on its `input_req`, the cross-wired pair forms no combinational loop.

Top module: `bidir_link_ctrl`

## Requirements
- R1: After reset the high-priority controller (HIGH_PRIO=1) is in Free and the low-priority controller (HIGH_PRIO=0) is in Idle. `link_state` encodes Idle=0, Wait=1, Free=2.
- R2: `output_req` depends on the state as follows:
  - In Free it equals `channel_req`.
  - In Wait it is 1.
  - In Idle it equals `channel_req`, and at the low-priority end it is additionally forced to 0 while `input_req` is 1.
- R3: A controller in Free with `channel_req` high is still in Free on the next cycle.
- R4: A controller in Free with `channel_req` low and `input_req` high moves to Idle on the next cycle.
- R5: A controller in Idle with `channel_req` high moves to Wait on the next cycle. At the low-priority end this also requires `input_req` low; otherwise it stays in Idle.
- R6: A controller in Wait with `channel_req` high and `input_req` low moves to Free on the next cycle. The high-priority end stays in Wait while `input_req` is high.
- R7: A controller in Wait with `channel_req` low withdraws to Idle on the next cycle.
- R8: A low-priority controller in Wait with `channel_req` high and `input_req` high yields to Idle on the next cycle.
- R9: When both ends are in Idle and both raise `channel_req` in the same cycle, the high-priority end enters Wait and the low-priority end stays in Idle.
- R10: `link_drive` is 1 exactly in Free, so it changes only with a state change. In a cross-connected pair the two ends are never both in Free.
- R11: A controller in Idle with `channel_req` low stays in Idle. A controller in Free with `input_req` low stays in Free.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both ends of the link |
| rst_n | input | 1 | Active-low synchronous reset |
| channel_req | input | 1 | A granted local packet needs this link |
| input_req | input | 1 | Request from the other end (its `output_req`) |
| output_req | output | 1 | Request to the other end |
| link_drive | output | 1 | 1 = this end drives the link, 0 = receives |
| link_state | output | 2 | Current state: Idle=0, Wait=1, Free=2 |

## Verification
The bench builds the cross-connected pair with the two values of HIGH_PRIO: instance u0 with 1 and instance u1 with 0. This puts the asymmetric arbitration within reach from both sides:

- the low-priority request masking;
- the yield from Wait;
- simultaneous claims on an unowned link.

A behavioural model of both ends is compared on every clock. The stimulus has directed phases (handover each way, withdrawal, contention) followed by a long random stretch, which probes the mutual-exclusion rule.

// File: rtl/bdl_pkg.sv
package bdl_pkg;
  localparam int ST_W = 2;
  typedef enum logic [ST_W-1:0] {
    LS_IDLE = 2'd0,
    LS_WAIT = 2'd1,
    LS_FREE = 2'd2
  } link_st_e;
endpackage

// File: rtl/bdl_fsm.sv
module bdl_fsm
  import bdl_pkg::*;
#(
  parameter bit HIGH_PRIO = 1'b1
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     channel_req,
  input  logic     input_req,
  output link_st_e st_q
);
  localparam link_st_e RESET_ST = HIGH_PRIO ? LS_FREE : LS_IDLE;

  link_st_e st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      LS_FREE: begin
        if (!channel_req && input_req) st_d = LS_IDLE;
      end
      LS_IDLE: begin
        if (channel_req && (HIGH_PRIO || !input_req)) st_d = LS_WAIT;
      end
      LS_WAIT: begin
        if (!channel_req)           st_d = LS_IDLE;
        else if (!input_req)        st_d = LS_FREE;
        else if (!HIGH_PRIO)        st_d = LS_IDLE;
      end
      default: st_d = LS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= RESET_ST;
    else        st_q <= st_d;
  end

  AST_KEEP_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == LS_FREE && channel_req) |=> st_q == LS_FREE); // R3
  AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == LS_FREE && !channel_req && input_req) |=> st_q == LS_IDLE); // R4
  AST_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == LS_WAIT && channel_req && !input_req) |=> st_q == LS_FREE); // R6
  AST_WITHDRAW: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == LS_WAIT && !channel_req) |=> st_q == LS_IDLE); // R7
  AST_NO_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == LS_IDLE) |=> st_q != LS_FREE); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == LS_IDLE && !channel_req) |=> st_q == LS_IDLE); // R11

  generate
    if (!HIGH_PRIO) begin : g_low
      AST_LOW_YIELD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == LS_WAIT && channel_req && input_req) |=> st_q == LS_IDLE); // R8
    end else begin : g_high
      AST_HIGH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == LS_WAIT && channel_req && input_req) |=> st_q == LS_WAIT); // R6
    end
  endgenerate
endmodule

// File: rtl/bdl_req_gen.sv
module bdl_req_gen
  import bdl_pkg::*;
#(
  parameter bit HIGH_PRIO = 1'b1
) (
  input  link_st_e st,
  input  logic     channel_req,
  input  logic     input_req,
  output logic     output_req
);
  generate
    if (HIGH_PRIO) begin : g_high
      always_comb begin
        unique case (st)
          LS_WAIT: output_req = 1'b1;
          default: output_req = channel_req;
        endcase
      end
    end else begin : g_low
      always_comb begin
        unique case (st)
          LS_WAIT: output_req = 1'b1;
          LS_IDLE: output_req = channel_req && !input_req;
          default: output_req = channel_req;
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/bdl_dir_decode.sv
module bdl_dir_decode
  import bdl_pkg::*;
(
  input  link_st_e        st,
  output logic            link_drive,
  output logic [ST_W-1:0] link_state
);
  assign link_drive = (st == LS_FREE);
  assign link_state = st;
endmodule

// File: rtl/bidir_link_ctrl.sv
module bidir_link_ctrl
  import bdl_pkg::*;
#(
  parameter bit HIGH_PRIO = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            channel_req,
  input  logic            input_req,
  output logic            output_req,
  output logic            link_drive,
  output logic [ST_W-1:0] link_state
);
  link_st_e st;

  bdl_fsm #(.HIGH_PRIO(HIGH_PRIO)) u_fsm (
    .clk(clk), .rst_n(rst_n), .channel_req(channel_req),
    .input_req(input_req), .st_q(st)
  );

  bdl_req_gen #(.HIGH_PRIO(HIGH_PRIO)) u_req (
    .st(st), .channel_req(channel_req), .input_req(input_req),
    .output_req(output_req)
  );

  bdl_dir_decode u_dir (
    .st(st), .link_drive(link_drive), .link_state(link_state)
  );

  AST_WAIT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (link_state == 2'd1) |-> output_req); // R2
  AST_FREE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (link_state == 2'd2) |-> (output_req == channel_req)); // R2
  AST_DRIVE_ON_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_drive) |-> $past(link_state) == 2'd1); // R10
endmodule

// File: tb/sim_bidir_link_ctrl.sv
module sim_bidir_link_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ch_h = 1'b0, ch_l = 1'b0;
  logic req_h, req_l, drv_h, drv_l;
  logic [1:0] st_h, st_l;
  int tests = 0, fails = 0, cyc = 0;
  int mh = 2, ml = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  bidir_link_ctrl #(.HIGH_PRIO(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .channel_req(ch_h), .input_req(req_l),
    .output_req(req_h), .link_drive(drv_h), .link_state(st_h));
  bidir_link_ctrl #(.HIGH_PRIO(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .channel_req(ch_l), .input_req(req_h),
    .output_req(req_l), .link_drive(drv_l), .link_state(st_l));

  // Behavioural model: 0 idle, 1 wait, 2 free
  function automatic bit m_out(int s, bit hi, bit ch, bit inq);
    if (s == 1) return 1'b1;
    if (s == 0) return ch && (hi || !inq);
    return ch;
  endfunction
  function automatic int m_next(int s, bit hi, bit ch, bit inq);
    if (s == 2) return (!ch && inq) ? 0 : 2;
    if (s == 0) return (ch && (hi || !inq)) ? 1 : 0;
    if (!ch) return 0;
    if (!inq) return 2;
    return hi ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    bit oh, ol;
    cyc++;
    if (!rst_n) begin
      mh = 2; ml = 0;
    end else begin
      oh = m_out(mh, 1'b1, ch_h, 1'b0);
      ol = m_out(ml, 1'b0, ch_l, oh);
      mh = m_next(mh, 1'b1, ch_h, ol);
      ml = m_next(ml, 1'b0, ch_l, oh);
    end
  end

  task automatic check(string t, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", t, act, exp, cyc);
    end
  endtask

  // one cycle: compare registered outputs, apply inputs, compare requests
  task automatic step(bit a, bit b);
    bit oh, ol;
    @(negedge clk);
    check({tag, " R10 state_h"}, st_h, mh);
    check({tag, " R10 state_l"}, st_l, ml);
    check("R10 drive_h", drv_h, mh == 2);
    check("R10 drive_l", drv_l, ml == 2);
    check("R10 exclusive", drv_h && drv_l, 0);
    ch_h = a; ch_l = b;
    #1;
    oh = m_out(mh, 1'b1, ch_h, 1'b0);
    ol = m_out(ml, 1'b0, ch_l, oh);
    check("R2 req_h", req_h, oh);
    check("R2 req_l", req_l, ol);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    check("R1 high in free", st_h, 2);
    check("R1 low in idle", st_l, 0);
    tag = "R11"; step(0, 0); step(0, 0);
    tag = "R3";  step(1, 1); step(1, 1);          // low masked, high keeps
    check("R5 low masked stays idle", st_l, 0);
    tag = "R4";  step(0, 1); step(0, 1); step(0, 1); // handover to low
    check("R6 low claims", st_l, 2);
    tag = "R6";  step(1, 1); step(1, 1);          // high waits on busy low
    check("R6 high holds wait", st_h, 1);
    step(1, 0); step(1, 0); step(1, 0);           // low releases, high claims
    check("R6 high back in free", st_h, 2);
    tag = "R7";  step(0, 1); step(0, 0); step(0, 0); // low wait then withdraw
    check("R7 both idle h", st_h, 0);
    check("R7 both idle l", st_l, 0);
    tag = "R9";  step(1, 1); step(1, 1);
    @(negedge clk);
    check("R9 contention h", st_h, 2);
    check("R9 contention l", st_l, 0);
    tag = "R8";  step(0, 0); step(0, 1); step(1, 1); step(1, 1); step(0, 1);
    tag = "R10";
    for (int i = 0; i < 4000; i++) step($urandom_range(0, 1), $urandom_range(0, 1));
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1000000;
    fails++; tests++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule